// File: doc/BRIEF.md
# Multicycle 16-bit Harvard Processor Core

This block is a small processor core with separate instruction and data storage, each 1024 words of 16 bits. Every instruction passes through four states: fetch, decode, execute and writeback. The core has sixteen 16-bit general registers and a 16-bit program counter. The arithmetic and logic group takes its right operand either from a register or from a sign-extended 6-bit literal. MOVE transfers data between registers, literals and data memory. A one-bit shift group fills with zero. The control group holds a register jump and six conditional branches, and each branch compares a register against R0.

There is no graceful exit. The core runs until it decodes a word outside the instruction set, then it halts and reports that word and the address it was fetched from. Both memories fill with 0xFFFF on reset, so any location that is never loaded traps. A second halt reason comes from an instruction-count limit, which stops a program that never terminates. A load port fills either memory while the core waits in idle. A read-back port and a register observation port let the environment inspect the final state.

Top module: `hcpu_core`

## Requirements
- R1: After reset, all registers and the PC read 0x0000, `halted` is 0 and `halt_status` is 0, and every location of both memories reads 0xFFFF through the read-back port.
- R2: An instruction word splits into family [15:13], mode [12:10], destination/first register [9:6] and operand 2 [5:0]. Families 000, 001, 010, 011 and 100 with mode 000 perform ADD, SUB, AND, OR and XOR of the first register and the sign-extended literal. The 16-bit result wraps and is written back to the first register.
- R3: The same families with mode 001 use the register numbered by bits [5:2] as the right operand, and bits [1:0] have no effect.
- R4: MOVE (family 101) mode 000 loads the sign-extended literal into the first register. Mode 001 loads the first register from the data word addressed by the low 10 bits of the register in bits [5:2].
- R5: MOVE mode 100 stores the sign-extended literal, and mode 101 stores the register in bits [5:2]. Both write to the data word addressed by the low 10 bits of the first register.
- R6: Family 110 mode 000 shifts the first register right by one, and mode 001 shifts it left by one. The vacated bit is 0 in both cases.
- R7: Family 111 modes 001 to 110 (BEQ, BNE, BLT, BGT, BLE, BGE) compare the first register with R0 as signed 16-bit values. When the condition holds, PC becomes the branch's own address plus the sign-extended bits [5:0]. Otherwise PC becomes the branch address plus one.
- R8: Family 111 mode 000 sets PC to the value of the first register.
- R9: A fetched word whose family/mode pair is not listed in R2 to R8 halts the core. The core sets `halt_status` = 1, `halt_instr` = the word and `halt_pc` = its address. The illegal pairs are: arithmetic modes 010 to 111, MOVE modes 010, 011, 110 and 111, shift modes 010 to 111, and control mode 111.
- R10: When MAX_INSTR instructions have completed, the next fetch halts the core with `halt_status` = 2 and `halt_pc` = the PC of that fetch.
- R11: Once halted, the core keeps `halted`, `halt_status`, `halt_instr` and `halt_pc` stable and changes no register or memory until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Leaves idle and starts execution at address 0 |
| ld_en | input | 1 | Load port write strobe |
| ld_sel | input | 1 | Load target: 0 code, 1 data |
| ld_addr | input | 10 | Load word address |
| ld_data | input | 16 | Load word value |
| rb_sel | input | 1 | Read-back source: 0 code, 1 data |
| rb_addr | input | 10 | Read-back word address |
| rb_data | output | 16 | Read-back word value (combinational) |
| dbg_reg_sel | input | 4 | Register number to observe |
| dbg_reg_data | output | 16 | Value of the observed register |
| halted | output | 1 | Core has stopped |
| halt_status | output | 2 | 0 running, 1 illegal instruction, 2 instruction limit |
| halt_instr | output | 16 | Offending word (0 for the limit halt) |
| halt_pc | output | 16 | Address where execution stopped |

## Verification
The assertions assume the load port is used only while the core sits in idle after reset, and never once `run` is high. This is why writes by the core and writes by the loader are never checked against each other. The assertions also assume `run` stays high for the whole run. The stimulus keeps to these rules: each program is loaded after a fresh reset, `run` is raised only after the last load, and it is lowered again only by the next reset. The bench never relies on the core's own halt to stop the loader.

// File: rtl/hcpu_pkg.sv
package hcpu_pkg;

  localparam int XLEN = 16;
  localparam int RIDX = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_HALT
  } cpu_state_e;

  localparam logic [1:0] HS_NONE    = 2'd0;
  localparam logic [1:0] HS_ILLEGAL = 2'd1;
  localparam logic [1:0] HS_WDOG    = 2'd2;

  localparam logic [2:0] FAM_MOVE  = 3'b101;
  localparam logic [2:0] FAM_SHIFT = 3'b110;
  localparam logic [2:0] FAM_CTRL  = 3'b111;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_PASSB, OP_SHR, OP_SHL
  } alu_op_e;

  typedef struct packed {
    logic    legal;
    alu_op_e aop;
    logic    use_lit;
    logic    rf_we;
    logic    mem_rd;
    logic    mem_we;
    logic    is_jr;
    logic    is_br;
    logic [2:0] br_cond;
  } dec_t;

  function automatic logic [XLEN-1:0] sext6(input logic [5:0] v);
    return {{(XLEN-6){v[5]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_fn(input alu_op_e op,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      OP_ADD:   r = a + b;
      OP_SUB:   r = a - b;
      OP_AND:   r = a & b;
      OP_OR:    r = a | b;
      OP_XOR:   r = a ^ b;
      OP_PASSB: r = b;
      OP_SHR:   r = a >> 1;
      default:  r = a << 1;
    endcase
    return r;
  endfunction

  function automatic logic br_fn(input logic [2:0] cond,
                                 input logic [XLEN-1:0] a,
                                 input logic [XLEN-1:0] r0);
    logic signed [XLEN-1:0] sa, sb;
    logic t;
    sa = $signed(a);
    sb = $signed(r0);
    case (cond)
      3'd1:    t = (sa == sb);
      3'd2:    t = (sa != sb);
      3'd3:    t = (sa <  sb);
      3'd4:    t = (sa >  sb);
      3'd5:    t = (sa <= sb);
      3'd6:    t = (sa >= sb);
      default: t = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/hcpu_decode.sv
module hcpu_decode
  import hcpu_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [2:0] fam, mode;
  assign fam  = instr[15:13];
  assign mode = instr[12:10];

  always_comb begin
    dec         = '0;
    dec.aop     = OP_PASSB;
    dec.br_cond = mode;
    case (fam)
      FAM_MOVE: begin
        case (mode)
          3'b000: begin dec.legal = 1'b1; dec.use_lit = 1'b1; dec.rf_we = 1'b1; end
          3'b001: begin dec.legal = 1'b1; dec.mem_rd = 1'b1; dec.rf_we = 1'b1; end
          3'b100: begin dec.legal = 1'b1; dec.use_lit = 1'b1; dec.mem_we = 1'b1; end
          3'b101: begin dec.legal = 1'b1; dec.mem_we = 1'b1; end
          default: dec.legal = 1'b0;
        endcase
      end
      FAM_SHIFT: begin
        dec.legal = (mode == 3'b000) || (mode == 3'b001);
        dec.rf_we = 1'b1;
        dec.aop   = (mode == 3'b000) ? OP_SHR : OP_SHL;
      end
      FAM_CTRL: begin
        dec.legal   = (mode != 3'b111);
        dec.is_jr   = (mode == 3'b000);
        dec.is_br   = (mode != 3'b000);
        dec.use_lit = 1'b1;
      end
      default: begin
        dec.legal   = (mode == 3'b000) || (mode == 3'b001);
        dec.use_lit = (mode == 3'b000);
        dec.rf_we   = 1'b1;
        case (fam)
          3'b000:  dec.aop = OP_ADD;
          3'b001:  dec.aop = OP_SUB;
          3'b010:  dec.aop = OP_AND;
          3'b011:  dec.aop = OP_OR;
          default: dec.aop = OP_XOR;
        endcase
      end
    endcase
  end

  always_comb begin
    if (dec.mem_we && dec.rf_we) assert (0) else $error("p_store_no_regwrite_r5");
  end
endmodule

// File: rtl/hcpu_regfile.sv
module hcpu_regfile
  import hcpu_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IW-1:0]   rb_idx,
  output logic [XLEN-1:0] rb_data,
  output logic [XLEN-1:0] r0_data,
  input  logic            we,
  input  logic [IW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [IW-1:0]   dbg_idx,
  output logic [XLEN-1:0] dbg_data
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign ra_data  = regs[ra_idx];
  assign rb_data  = regs[rb_idx];
  assign r0_data  = regs[0];
  assign dbg_data = regs[dbg_idx];
endmodule

// File: rtl/hcpu_wordmem.sv
module hcpu_wordmem
  import hcpu_pkg::*;
#(
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cpu_addr,
  output logic [XLEN-1:0] cpu_rdata,
  input  logic            cpu_we,
  input  logic [XLEN-1:0] cpu_wdata,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (cpu_we) begin
      mem[cpu_addr] <= cpu_wdata;
    end
  end

  assign cpu_rdata = mem[cpu_addr];
  assign rb_data   = mem[rb_addr];
endmodule

// File: rtl/hcpu_core.sv
module hcpu_core
  import hcpu_pkg::*;
#(
  parameter int AW        = 10,
  parameter int MAX_INSTR = 100000,
  localparam int CNT_W    = $clog2(MAX_INSTR + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [AW-1:0]   ld_addr,
  input  logic [15:0]     ld_data,
  input  logic            rb_sel,
  input  logic [AW-1:0]   rb_addr,
  output logic [15:0]     rb_data,
  input  logic [3:0]      dbg_reg_sel,
  output logic [15:0]     dbg_reg_data,
  output logic            halted,
  output logic [1:0]      halt_status,
  output logic [15:0]     halt_instr,
  output logic [15:0]     halt_pc
);
  cpu_state_e st;
  logic [XLEN-1:0] pc, ir, opa, opb, r0v, result;
  logic [CNT_W-1:0] icount;
  alu_op_e q_aop;
  logic q_rf_we, q_mem_rd, q_mem_we, q_is_jr, q_is_br, take_q;
  logic [2:0] q_cond;

  dec_t dec;
  logic [XLEN-1:0] ra_data, rb_rdata, r0_data, cmem_rdata, dmem_rdata;
  logic [XLEN-1:0] cmem_rb, dmem_rb;

  // named internal events
  logic fetch_fire, illegal_evt, wdog_evt, rf_we, dmem_we, br_taken, pc_redirect;
  logic [AW-1:0] dmem_addr;

  assign wdog_evt    = (st == ST_FETCH) && (icount == CNT_W'(MAX_INSTR));
  assign fetch_fire  = (st == ST_FETCH) && !wdog_evt;
  assign illegal_evt = (st == ST_DECODE) && !dec.legal;
  assign dmem_we     = (st == ST_EXEC) && q_mem_we;
  assign rf_we       = (st == ST_WB) && q_rf_we;
  assign br_taken    = q_is_br && br_fn(q_cond, opa, r0v);
  assign pc_redirect = q_is_jr || take_q;
  assign dmem_addr   = q_mem_we ? opa[AW-1:0] : opb[AW-1:0];

  hcpu_decode u_dec (.instr(ir), .dec(dec));

  hcpu_regfile #(.NREG(16)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ir[9:6]), .ra_data(ra_data),
    .rb_idx(ir[5:2]), .rb_data(rb_rdata),
    .r0_data(r0_data),
    .we(rf_we), .wa(ir[9:6]), .wd(result),
    .dbg_idx(dbg_reg_sel), .dbg_data(dbg_reg_data)
  );

  hcpu_wordmem #(.AW(AW)) u_cmem (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(pc[AW-1:0]), .cpu_rdata(cmem_rdata),
    .cpu_we(1'b0), .cpu_wdata('0),
    .ld_en(ld_en && !ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rb_addr(rb_addr), .rb_data(cmem_rb)
  );

  hcpu_wordmem #(.AW(AW)) u_dmem (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(dmem_addr), .cpu_rdata(dmem_rdata),
    .cpu_we(dmem_we), .cpu_wdata(opb),
    .ld_en(ld_en && ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rb_addr(rb_addr), .rb_data(dmem_rb)
  );

  assign rb_data = rb_sel ? dmem_rb : cmem_rb;
  assign halted  = (st == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pc <= '0; ir <= '0; opa <= '0; opb <= '0; r0v <= '0; result <= '0;
      icount <= '0;
      q_aop <= OP_PASSB; q_rf_we <= 1'b0; q_mem_rd <= 1'b0; q_mem_we <= 1'b0;
      q_is_jr <= 1'b0; q_is_br <= 1'b0; q_cond <= '0; take_q <= 1'b0;
      halt_status <= HS_NONE; halt_instr <= '0; halt_pc <= '0;
    end else begin
      case (st)
        ST_IDLE: if (run) st <= ST_FETCH;
        ST_FETCH: begin
          if (wdog_evt) begin
            st <= ST_HALT;
            halt_status <= HS_WDOG;
            halt_instr  <= '0;
            halt_pc     <= pc;
          end else begin
            ir <= cmem_rdata;
            st <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (illegal_evt) begin
            st <= ST_HALT;
            halt_status <= HS_ILLEGAL;
            halt_instr  <= ir;
            halt_pc     <= pc;
          end else begin
            q_aop <= dec.aop; q_rf_we <= dec.rf_we; q_mem_rd <= dec.mem_rd;
            q_mem_we <= dec.mem_we; q_is_jr <= dec.is_jr; q_is_br <= dec.is_br;
            q_cond <= dec.br_cond;
            opa <= ra_data;
            opb <= dec.use_lit ? sext6(ir[5:0]) : rb_rdata;
            r0v <= r0_data;
            st  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          result <= q_mem_rd ? dmem_rdata : alu_fn(q_aop, opa, opb);
          take_q <= br_taken;
          st     <= ST_WB;
        end
        ST_WB: begin
          if (q_is_jr)     pc <= opa;
          else if (take_q) pc <= pc + sext6(ir[5:0]);
          else             pc <= pc + 16'd1;
          icount <= icount + 1'b1;
          take_q <= 1'b0;
          st     <= ST_FETCH;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(halt_status) && $stable(halt_instr) && $stable(halt_pc));

  p_no_update_halted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !rf_we && !dmem_we && $stable(pc));

  p_illegal_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_evt |=> halted && halt_status == HS_ILLEGAL
                    && halt_instr == $past(ir) && halt_pc == $past(pc));

  p_wdog_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt |=> halted && halt_status == HS_WDOG);

  p_icount_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    icount <= CNT_W'(MAX_INSTR));

  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB && !pc_redirect) |=> pc == $past(pc) + 16'd1);

  p_store_is_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> ir[15:13] == FAM_MOVE && ir[12]);

  p_status_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> halt_status == HS_NONE);

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |=> st == ST_DECODE);
endmodule

// File: tb/tb_hcpu_core.sv
`timescale 1ns/1ps
module tb_hcpu_core;
  localparam int AW = 10;
  localparam int MAXI = 40;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic ld_en = 1'b0, ld_sel = 1'b0, rb_sel = 1'b0;
  logic [AW-1:0] ld_addr = '0, rb_addr = '0;
  logic [15:0] ld_data = '0;
  logic [3:0] dbg_reg_sel = '0;
  logic [15:0] rb_data, dbg_reg_data, halt_instr, halt_pc;
  logic halted;
  logic [1:0] halt_status;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  hcpu_core #(.AW(AW), .MAX_INSTR(MAXI)) dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rb_sel(rb_sel), .rb_addr(rb_addr), .rb_data(rb_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .halted(halted), .halt_status(halt_status),
    .halt_instr(halt_instr), .halt_pc(halt_pc)
  );

  function automatic logic [15:0] enc(int fam, int mode, int r1, int op2);
    return {fam[2:0], mode[2:0], r1[3:0], op2[5:0]};
  endfunction

  function automatic logic [15:0] sx(logic [5:0] v);
    return v[5] ? (16'hFFC0 | {10'd0, v}) : {10'd0, v};
  endfunction

  function automatic logic [15:0] model_op(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a + (~b) + 16'd1;
      2: return a & b;
      3: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic bit model_br(int c, logic [15:0] x, logic [15:0] y);
    int sx_i, sy_i;
    sx_i = x[15] ? int'(x) - 65536 : int'(x);
    sy_i = y[15] ? int'(y) - 65536 : int'(y);
    case (c)
      1: return sx_i == sy_i;
      2: return sx_i != sy_i;
      3: return sx_i < sy_i;
      4: return sx_i > sy_i;
      5: return sx_i <= sy_i;
      default: return sx_i >= sy_i;
    endcase
  endfunction

  function automatic bit legal_pair(int fam, int mode);
    if (fam <= 4) return mode <= 1;
    if (fam == 5) return mode == 0 || mode == 1 || mode == 4 || mode == 5;
    if (fam == 6) return mode <= 1;
    return mode != 7;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; ld_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(bit sel, int addr, logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = addr[AW-1:0]; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(bit sel, int addr, output logic [15:0] d);
    rb_sel = sel; rb_addr = addr[AW-1:0];
    #1 d = rb_data;
  endtask

  task automatic reg_peek(int idx, output logic [15:0] d);
    dbg_reg_sel = idx[3:0];
    #1 d = dbg_reg_data;
  endtask

  task automatic go();
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, w;
    logic [15:0] va [4], vb [4];
    logic [5:0]  lits [4];
    logic [15:0] bx [6], by [6];
    va = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0F0F};
    vb = '{16'h0001, 16'hFFFF, 16'h8001, 16'h3C3C};
    lits = '{6'h1F, 6'h21, 6'h00, 6'h3F};
    bx = '{16'h0005, 16'h0003, 16'h0007, 16'hFFFE, 16'h0001, 16'h8000};
    by = '{16'h0005, 16'h0007, 16'h0003, 16'h0001, 16'hFFFE, 16'h7FFF};

    // R1: reset state
    do_reset();
    #1;
    chk("R1 halted", {15'd0, halted}, 16'd0);
    chk("R1 status", {14'd0, halt_status}, 16'd0);
    for (int a = 0; a < 1024; a += 97) begin
      peek(1'b0, a, v); chk("R1 code fill", v, 16'hFFFF);
      peek(1'b1, a, v); chk("R1 data fill", v, 16'hFFFF);
    end
    for (int r = 0; r < 16; r++) begin
      reg_peek(r, v); chk("R1 reg zero", v, 16'h0000);
    end

    // R2 R3 R4 R5: arithmetic sweep
    for (int op = 0; op < 5; op++) begin
      for (int k = 0; k < 4; k++) begin
        do_reset();
        load(1, 0, va[k]); load(1, 1, vb[k]);
        load(0, 0, enc(5, 0, 2, 0));
        load(0, 1, enc(5, 1, 1, 2 << 2));
        load(0, 2, enc(5, 0, 3, 1));
        load(0, 3, enc(5, 1, 4, 3 << 2));
        load(0, 4, enc(op, 1, 1, (4 << 2) | 3));
        load(0, 5, enc(5, 0, 5, 2));
        load(0, 6, enc(5, 5, 5, 1 << 2));
        load(0, 7, enc(op, 0, 4, int'(lits[k])));
        load(0, 8, enc(5, 0, 6, 3));
        load(0, 9, enc(5, 5, 6, 4 << 2));
        go();
        peek(1, 2, v); chk("R3 reg operand", v, model_op(op, va[k], vb[k]));
        peek(1, 3, v); chk("R2 literal operand", v, model_op(op, vb[k], sx(lits[k])));
        reg_peek(4, v); chk("R2 writeback", v, model_op(op, vb[k], sx(lits[k])));
        chk("R9 end pc", halt_pc, 16'd10);
      end
    end

    // R6: shifts
    for (int k = 0; k < 4; k++) begin
      do_reset();
      load(1, 0, va[k] ^ vb[k]);
      load(0, 0, enc(5, 0, 2, 0));
      load(0, 1, enc(5, 1, 1, 2 << 2));
      load(0, 2, enc(5, 1, 7, 2 << 2));
      load(0, 3, enc(6, 0, 1, 0));
      load(0, 4, enc(6, 1, 7, 0));
      load(0, 5, enc(5, 0, 5, 2));
      load(0, 6, enc(5, 5, 5, 1 << 2));
      load(0, 7, enc(5, 0, 6, 3));
      load(0, 8, enc(5, 5, 6, 7 << 2));
      go();
      w = va[k] ^ vb[k];
      peek(1, 2, v); chk("R6 right", v, {1'b0, w[15:1]});
      peek(1, 3, v); chk("R6 left", v, {w[14:0], 1'b0});
    end

    // R7: branches against R0
    for (int c = 1; c <= 6; c++) begin
      for (int p = 0; p < 6; p++) begin
        bit tk;
        do_reset();
        load(1, 0, by[p]); load(1, 1, bx[p]);
        load(0, 0, enc(5, 0, 2, 0));
        load(0, 1, enc(5, 1, 0, 2 << 2));
        load(0, 2, enc(5, 0, 2, 1));
        load(0, 3, enc(5, 1, 1, 2 << 2));
        load(0, 4, enc(5, 0, 3, 5));
        load(0, 5, enc(7, c, 1, 3));
        load(0, 6, enc(5, 4, 3, 1));
        load(0, 8, enc(5, 4, 3, 2));
        go();
        tk = model_br(c, bx[p], by[p]);
        peek(1, 5, v); chk("R7 path", v, tk ? 16'd2 : 16'd1);
        chk("R7 end pc", halt_pc, tk ? 16'd9 : 16'd7);
      end
    end

    // R8 R4: register jump, negative literal move
    do_reset();
    load(0, 0, enc(5, 0, 3, 5));
    load(0, 1, enc(5, 0, 4, 12));
    load(0, 2, enc(7, 0, 4, 0));
    load(0, 3, enc(5, 4, 3, 1));
    load(0, 12, enc(5, 0, 8, 6'h3B));
    load(0, 13, enc(5, 4, 3, 3));
    go();
    peek(1, 5, v); chk("R8 jump target", v, 16'd3);
    chk("R8 end pc", halt_pc, 16'd14);
    reg_peek(8, v); chk("R4 literal sign", v, 16'hFFFB);

    // R7 backward branch loop, then R11 stability
    do_reset();
    load(0, 0, enc(5, 0, 5, 3));
    load(0, 1, enc(1, 0, 5, 1));
    load(0, 2, enc(7, 2, 5, 6'h3F));
    go();
    chk("R7 backward end pc", halt_pc, 16'd3);
    reg_peek(5, v); chk("R7 loop count", v, 16'd0);
    repeat (20) @(negedge clk);
    chk("R11 halted held", {15'd0, halted}, 16'd1);
    chk("R11 status held", {14'd0, halt_status}, 16'd1);
    chk("R11 pc held", halt_pc, 16'd3);
    chk("R11 word held", halt_instr, 16'hFFFF);
    reg_peek(5, v); chk("R11 reg held", v, 16'd0);

    // R10: instruction limit
    do_reset();
    load(0, 0, enc(7, 1, 0, 0));
    go();
    chk("R10 status", {14'd0, halt_status}, 16'd2);
    chk("R10 pc", halt_pc, 16'd0);
    chk("R10 word", halt_instr, 16'd0);

    // R9: sweep of every family/mode pair
    for (int fm = 0; fm < 64; fm++) begin
      logic [15:0] word;
      bit ok;
      word = enc(fm >> 3, fm & 7, 1, 1);
      ok = legal_pair(fm >> 3, fm & 7);
      do_reset();
      load(0, 0, enc(5, 0, 1, 2));
      load(0, 1, word);
      go();
      chk("R9 status", {14'd0, halt_status}, 16'd1);
      chk("R9 trap pc", halt_pc, ok ? 16'd2 : 16'd1);
      chk("R9 trap word", halt_instr, ok ? 16'hFFFF : word);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule